// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit DMA Engine

This block is a small four-channel data mover that works alongside a CPU. Each channel is armed with a source address, a destination address, a 16-bit transfer count, a mode word and a start-vector code. When the interrupt line that a channel has claimed pulses, or when software pulses the soft-start input for channels that chose the soft code, the channel becomes pending. The engine then moves exactly one data unit of 1, 2 or 4 bytes. It reads the unit from the source address and writes it to the destination address on the next cycle. After the write, each address is stepped by the unit size as the mode word directs, and the count drops by one.

When a channel's count goes from 1 to 0, the channel gives up its start vector and emits a one-cycle end pulse. From then on, that interrupt line is forwarded to the CPU instead. A count loaded as zero means 65536 units. A counting mode skips the bus entirely: it only steps the source address and decrements the count, which lets a channel act as an event counter.

The controller has four named states:
- `ST_IDLE` waits for any pending channel, grants the lowest-numbered one and clears its pending flag.
- From `ST_IDLE` it goes to `ST_READ` for a normal channel, or to `ST_COUNT` for a counting channel.
- `ST_READ` drives the read strobe and always goes to `ST_WRITE`.
- `ST_WRITE` drives the write strobe and performs the update.
- `ST_COUNT` performs the update with no strobe.
- Both `ST_WRITE` and `ST_COUNT` return to `ST_IDLE`.

Top module: `udma_engine`

## Requirements
- R1: A granted normal-mode channel drives `bus_rd` for exactly one cycle at its source address. In the cycle right after, it drives `bus_wr` at its destination address. The two strobes are never high together. An operation takes three cycles, with `ST_IDLE`, `ST_READ` and `ST_WRITE` each lasting one cycle.
- R2: Address registers hold 32 bits. `bus_addr` carries only bits 23:0 of the selected register, and bits 31:24 have no effect on the bus.
- R3: The mode bits [1:0] select the unit size: 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes.
  - Byte enables for 1 byte are `1 << addr[1:0]`. For 2 bytes they are `4'b1100` if addr[1] is set, else `4'b0011`. For 4 bytes they are `4'b1111`.
  - The unit is taken from the source lanes and placed on the destination lanes of `bus_wdata`. Other lanes are zero.
  - Misaligned addresses are used unchanged, with no fault.
- R4: Mode bits [3:2] step the source address and mode bits [5:4] step the destination address after each unit. Code 1 adds the unit size, code 2 subtracts it, and codes 0 or 3 hold the address. The arithmetic is modulo 2^32.
- R5: Each unit decrements the 16-bit count. When the count goes from 1 to 0, the channel's vector code becomes 0 and `eot[ch]` pulses for one cycle. A count loaded as 0 wraps to 0xFFFF and does not end the channel.
- R6: The vector code is 6 bits. Code 0 disables the channel, codes 1..33 select `irq_in[code-1]`, code 34 selects `soft_start`, and codes 35..63 never trigger. `irq_pass[i]` equals `irq_in[i]` unless some channel currently holds code i+1.
- R7: When several channels are pending in `ST_IDLE`, the lowest-numbered one is served first. Each grant serves one unit.
- R8: A channel's pending flag clears when it is granted. Any number of triggers that arrive while the flag is set produce one unit.
- R9: With mode bit [6] set, a unit makes no bus cycle. It steps only the source address and decrements the count, including the R5 end handling.
- R10: After reset, both strobes are low, `eot` is zero, all channels hold code 0 and every `irq_in` is passed through.
- R11: A config write (`cfg_we`) loads the field `cfg_field` of channel `cfg_ch` from `cfg_wdata`. The field codes are: 0 source, 1 destination, 2 count (bits 15:0), 3 mode (bits 6:0) and 4 vector (bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | 2 | Channel written |
| cfg_field | input | 3 | Field written (R11 codes) |
| cfg_wdata | input | 32 | Config write data |
| irq_in | input | 33 | Hardware interrupt requests, one trigger per high cycle |
| soft_start | input | 1 | Software start for channels holding code 34 |
| irq_pass | output | 33 | Requests forwarded to the CPU |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 24 | Bus address |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the read cycle |
| eot | output | 4 | One-cycle end-of-transfer pulse per channel |

## Verification
Directed cases try the unit move with the following patterns:
- Each of the three sizes, at both aligned and odd addresses, with upper address bits set. These separate a byte-lane or enable error from an address-truncation error.
- A destination that steps below zero, which exposes stepping arithmetic done at the wrong width.
- Counts of 1, 2, 3 and 0, which distinguish a missing end pulse from one that fires early and from the 65536 wrap.
- Simultaneous triggers on two channels, and a double trigger during another channel's transfer, which separate the priority order from the count-once pending rule.
- A counting-mode sequence followed by a normal unit, which shows through the next read address that the source stepped with no bus traffic.

Seeded random channel setups then cover all size and step combinations.

// File: rtl/udma_pkg.sv
package udma_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 7;
    localparam int VSEL_W = 6;

    localparam logic [2:0] FLD_SRC  = 3'd0;
    localparam logic [2:0] FLD_DST  = 3'd1;
    localparam logic [2:0] FLD_CNT  = 3'd2;
    localparam logic [2:0] FLD_MODE = 3'd3;
    localparam logic [2:0] FLD_VEC  = 3'd4;

    localparam logic [1:0] STEP_INC = 2'd1;
    localparam logic [1:0] STEP_DEC = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_COUNT = 2'd3
    } udma_state_e;

    function automatic logic [REG_W-1:0] unit_bytes(input logic [1:0] size);
        unique case (size)
            2'd0:    unit_bytes = 32'd1;
            2'd1:    unit_bytes = 32'd2;
            default: unit_bytes = 32'd4;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] next_addr(input logic [REG_W-1:0] a,
                                                   input logic [1:0] step,
                                                   input logic [1:0] size);
        if (step == STEP_INC)      next_addr = a + unit_bytes(size);
        else if (step == STEP_DEC) next_addr = a - unit_bytes(size);
        else                       next_addr = a;
    endfunction
endpackage

// File: rtl/udma_lane.sv
module udma_lane (
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic [3:0] be,
    output logic [1:0] lane
);
    always_comb begin
        unique case (size)
            2'd0: begin
                lane = addr_lo;
                be   = 4'b0001 << addr_lo;
            end
            2'd1: begin
                lane = {addr_lo[1], 1'b0};
                be   = addr_lo[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                lane = 2'd0;
                be   = 4'b1111;
            end
        endcase
    end
endmodule

// File: rtl/udma_chan.sv
module udma_chan
    import udma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_field,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               adv,
    output logic [REG_W-1:0]   src_q,
    output logic [REG_W-1:0]   dst_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [MODE_W-1:0]  mode_q,
    output logic [VSEL_W-1:0]  vsel_q,
    output logic               last
);
    logic       counting;
    logic [1:0] size;

    assign size     = mode_q[1:0];
    assign counting = mode_q[6];
    assign last     = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            vsel_q <= '0;
        end else if (adv) begin
            src_q <= next_addr(src_q, mode_q[3:2], size);
            if (!counting) dst_q <= next_addr(dst_q, mode_q[5:4], size);
            cnt_q <= cnt_q - CNT_W'(1);
            if (last) vsel_q <= '0;
        end else if (wr_en) begin
            unique case (wr_field)
                FLD_SRC:  src_q  <= wr_data;
                FLD_DST:  dst_q  <= wr_data;
                FLD_CNT:  cnt_q  <= wr_data[CNT_W-1:0];
                FLD_MODE: mode_q <= wr_data[MODE_W-1:0];
                FLD_VEC:  vsel_q <= wr_data[VSEL_W-1:0];
                default:  ;
            endcase
        end
    end

    // R5: reaching zero releases the vector
    p_vsel_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv && last |=> vsel_q == '0);
    // R5: every unit takes one off the count
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/udma_pend.sv
module udma_pend
    import udma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NIRQ = 33,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int NLINE = 1 << VSEL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0][VSEL_W-1:0]   vsel,
    input  logic [NIRQ-1:0]              irq_in,
    input  logic                         soft_start,
    input  logic                         grant,
    input  logic [CH_W-1:0]              grant_ch,
    output logic [NCH-1:0]               pend,
    output logic [CH_W-1:0]              pick,
    output logic [NIRQ-1:0]              irq_pass
);
    logic [NLINE-1:0] vec_line;
    logic [NLINE-1:0] claim_line;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   clr;
    logic             unused_claim;

    always_comb begin
        vec_line             = '0;
        vec_line[NIRQ:1]     = irq_in;
        vec_line[NIRQ+1]     = soft_start;
        claim_line           = '0;
        for (int c = 0; c < NCH; c++) begin
            hit[c]                = vec_line[vsel[c]];
            claim_line[vsel[c]]   = 1'b1;
        end
    end

    assign irq_pass     = irq_in & ~claim_line[NIRQ:1];
    assign unused_claim = claim_line[0] ^ (|claim_line[NLINE-1:NIRQ+1]);
    assign clr          = grant ? (NCH'(1) << grant_ch) : '0;

    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pend[c]) pick = CH_W'(c);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | hit;
    end

    // R8: a grant clears the flag unless a fresh trigger lands in that cycle
    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !hit[grant_ch] |=> !pend[$past(grant_ch)]);
    // R7: the granted channel is the lowest pending one
    p_pick_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend[grant_ch] && ((pend & ((NCH'(1) << grant_ch) - NCH'(1))) == '0));
endmodule

// File: rtl/udma_engine.sv
module udma_engine
    import udma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NIRQ = 33,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [NIRQ-1:0]   irq_in,
    input  logic              soft_start,
    output logic [NIRQ-1:0]   irq_pass,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_be,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    eot
);
    udma_state_e state_q, state_d;
    logic [CH_W-1:0]  cur_q;
    logic [REG_W-1:0] unit_q;

    logic [NCH-1:0][REG_W-1:0]  src_a, dst_a;
    logic [NCH-1:0][CNT_W-1:0]  cnt_a;
    logic [NCH-1:0][MODE_W-1:0] mode_a;
    logic [NCH-1:0][VSEL_W-1:0] vsel_a;
    logic [NCH-1:0] last_a, adv_a, pend;
    logic [CH_W-1:0] pick;
    logic grant, adv_any;

    logic [REG_W-1:0]  cur_src, cur_dst, unit_mask;
    logic [MODE_W-1:0] cur_mode;
    logic [3:0] src_be, dst_be;
    logic [1:0] src_lane, dst_lane;
    logic       unused_hi;

    assign cur_src   = src_a[cur_q];
    assign cur_dst   = dst_a[cur_q];
    assign cur_mode  = mode_a[cur_q];
    assign unused_hi = ^{cur_src[REG_W-1:ADDR_W], cur_dst[REG_W-1:ADDR_W], cnt_a};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            udma_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (cfg_we && (cfg_ch == CH_W'(c))),
                .wr_field (cfg_field),
                .wr_data  (cfg_wdata),
                .adv      (adv_a[c]),
                .src_q    (src_a[c]),
                .dst_q    (dst_a[c]),
                .cnt_q    (cnt_a[c]),
                .mode_q   (mode_a[c]),
                .vsel_q   (vsel_a[c]),
                .last     (last_a[c])
            );
        end
    endgenerate

    udma_pend #(.NCH(NCH), .NIRQ(NIRQ)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsel       (vsel_a),
        .irq_in     (irq_in),
        .soft_start (soft_start),
        .grant      (grant),
        .grant_ch   (pick),
        .pend       (pend),
        .pick       (pick),
        .irq_pass   (irq_pass)
    );

    udma_lane u_src_lane (.size(cur_mode[1:0]), .addr_lo(cur_src[1:0]), .be(src_be), .lane(src_lane));
    udma_lane u_dst_lane (.size(cur_mode[1:0]), .addr_lo(cur_dst[1:0]), .be(dst_be), .lane(dst_lane));

    always_comb begin
        unique case (cur_mode[1:0])
            2'd0:    unit_mask = 32'h0000_00FF;
            2'd1:    unit_mask = 32'h0000_FFFF;
            default: unit_mask = 32'hFFFF_FFFF;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        adv_any = 1'b0;
        unique case (state_q)
            ST_IDLE: if (|pend) begin
                grant   = 1'b1;
                state_d = mode_a[pick][6] ? ST_COUNT : ST_READ;
            end
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin adv_any = 1'b1; state_d = ST_IDLE; end
            ST_COUNT: begin adv_any = 1'b1; state_d = ST_IDLE; end
        endcase
    end

    assign adv_a = adv_any ? (NCH'(1) << cur_q) : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            unit_q  <= '0;
            eot     <= '0;
        end else begin
            state_q <= state_d;
            if (grant) cur_q <= pick;
            if (state_q == ST_READ)
                unit_q <= (bus_rdata >> {src_lane, 3'b000}) & unit_mask;
            eot <= (adv_any && last_a[cur_q]) ? (NCH'(1) << cur_q) : '0;
        end
    end

    // outputs
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_be    = '0;
        bus_wdata = '0;
        unique case (state_q)
            ST_READ: begin
                bus_rd   = 1'b1;
                bus_addr = cur_src[ADDR_W-1:0];
                bus_be   = src_be;
            end
            ST_WRITE: begin
                bus_wr    = 1'b1;
                bus_addr  = cur_dst[ADDR_W-1:0];
                bus_be    = dst_be;
                bus_wdata = unit_q << {dst_lane, 3'b000};
            end
            default: ;
        endcase
    end

    p_rd_then_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr && !bus_rd);
    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_eot_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eot));
    p_eot_after_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        |eot |-> $past(state_q == ST_WRITE || state_q == ST_COUNT));
    p_be_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $countones(bus_be) == int'(unit_bytes(cur_mode[1:0])));
    p_count_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant && mode_a[pick][6] |=> !bus_rd ##1 !bus_wr);
endmodule

// File: tb/test_udma_engine.sv
`timescale 1ns/1ps
module test_udma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic [32:0] irq_in = '0;
    logic        soft_start = 1'b0;
    logic [32:0] irq_pass;
    logic        bus_rd, bus_wr;
    logic [23:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0]  eot;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [23:0] a);
        return ({8'h00, a[23:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction
    assign bus_rdata = pat(bus_addr);

    udma_engine i_udma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .irq_in(irq_in),
        .soft_start(soft_start), .irq_pass(irq_pass), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eot(eot)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [23:0] rd_a_q[$], wr_a_q[$];
    logic [3:0]  rd_b_q[$], wr_b_q[$];
    logic [31:0] wr_d_q[$];
    int          rd_c_q[$], wr_c_q[$];
    int          eot_cnt[4], eot_exp[4];

    logic [31:0] m_src[4], m_dst[4];
    logic [15:0] m_cnt[4];
    logic [6:0]  m_mode[4];
    logic [5:0]  m_vsel[4];

    function automatic logic [3:0] x_be(input logic [1:0] s, input logic [1:0] a);
        if (s == 2'd0) return 4'b0001 << a;
        if (s == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction
    function automatic int x_lane(input logic [1:0] s, input logic [1:0] a);
        if (s == 2'd0) return int'(a);
        if (s == 2'd1) return a[1] ? 2 : 0;
        return 0;
    endfunction
    function automatic logic [31:0] x_mask(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] x_step(input logic [31:0] a, input logic [1:0] st, input logic [1:0] s);
        logic [31:0] n;
        n = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
        if (st == 2'd1) return a + n;
        if (st == 2'd2) return a - n;
        return a;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (bus_rd) begin rd_a_q.push_back(bus_addr); rd_b_q.push_back(bus_be); rd_c_q.push_back(cyc); end
            if (bus_wr) begin wr_a_q.push_back(bus_addr); wr_b_q.push_back(bus_be);
                              wr_d_q.push_back(bus_wdata); wr_c_q.push_back(cyc); end
            for (int c = 0; c < 4; c++) if (eot[c]) eot_cnt[c]++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d cycles expected<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cfg(input int c, input logic [2:0] f, input logic [31:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = 2'(c); cfg_field = f; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (f)
            3'd0: m_src[c] = v;
            3'd1: m_dst[c] = v;
            3'd2: m_cnt[c] = v[15:0];
            3'd3: m_mode[c] = v[6:0];
            3'd4: m_vsel[c] = v[5:0];
            default: ;
        endcase
    endtask

    task automatic setup(input int c, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] n, input logic [6:0] m, input logic [5:0] v);
        cfg(c, 3'd0, s); cfg(c, 3'd1, d); cfg(c, 3'd2, {16'h0, n});
        cfg(c, 3'd3, {25'h0, m}); cfg(c, 3'd4, {26'h0, v});
    endtask

    // pulse hardware vector v (1..33) and check forwarding (R6)
    task automatic pulse(input int v, input logic exp_pass);
        @(posedge clk); #1;
        irq_in[v-1] = 1'b1;
        #0.5;
        chk("R6", "irq_pass forwarding", {31'h0, irq_pass[v-1]}, {31'h0, exp_pass});
        @(posedge clk); #1;
        irq_in = '0;
    endtask

    task automatic expect_unit(input int c);
        logic [31:0] unit, wd;
        logic [1:0]  s;
        int t;
        t = 0;
        while (wr_a_q.size() == 0 && t < 200) begin @(negedge clk); t++; end
        chk("R1", "write seen", {31'h0, wr_a_q.size() != 0}, 32'h1);
        chk("R1", "read seen", {31'h0, rd_a_q.size() != 0}, 32'h1);
        if (wr_a_q.size() != 0 && rd_a_q.size() != 0) begin
            s = m_mode[c][1:0];
            unit = (pat(m_src[c][23:0]) >> (8 * x_lane(s, m_src[c][1:0]))) & x_mask(s);
            wd = unit << (8 * x_lane(s, m_dst[c][1:0]));
            chk("R2", "read address", {8'h0, rd_a_q.pop_front()}, {8'h0, m_src[c][23:0]});
            chk("R3", "read enables", {28'h0, rd_b_q.pop_front()}, {28'h0, x_be(s, m_src[c][1:0])});
            chk("R2", "write address", {8'h0, wr_a_q.pop_front()}, {8'h0, m_dst[c][23:0]});
            chk("R3", "write enables", {28'h0, wr_b_q.pop_front()}, {28'h0, x_be(s, m_dst[c][1:0])});
            chk("R3", "write data", wr_d_q.pop_front(), wd);
            chk("R1", "write follows read", 32'(wr_c_q.pop_front() - rd_c_q.pop_front()), 32'd1);
        end
        m_src[c] = x_step(m_src[c], m_mode[c][3:2], s);
        m_dst[c] = x_step(m_dst[c], m_mode[c][5:4], s);
        if (m_cnt[c] == 16'd1) begin eot_exp[c]++; m_vsel[c] = '0; end
        m_cnt[c] = m_cnt[c] - 16'd1;
        repeat (3) @(negedge clk);
        chk("R5", "end pulses", 32'(eot_cnt[c]), 32'(eot_exp[c]));
    endtask

    task automatic expect_count(input int c);
        repeat (8) @(negedge clk);
        chk("R9", "no bus traffic in counting mode", 32'(rd_a_q.size() + wr_a_q.size()), 32'd0);
        m_src[c] = x_step(m_src[c], m_mode[c][3:2], m_mode[c][1:0]);
        if (m_cnt[c] == 16'd1) begin eot_exp[c]++; m_vsel[c] = '0; end
        m_cnt[c] = m_cnt[c] - 16'd1;
        chk("R9", "counting end pulses", 32'(eot_cnt[c]), 32'(eot_exp[c]));
    endtask

    task automatic quiet(input string req);
        repeat (12) @(negedge clk);
        chk(req, "no extra bus cycles", 32'(rd_a_q.size() + wr_a_q.size()), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin
            eot_cnt[c] = 0; eot_exp[c] = 0;
            m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_mode[c] = '0; m_vsel[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "strobes after reset", {30'h0, bus_rd, bus_wr}, 32'h0);
        chk("R10", "eot after reset", {28'h0, eot}, 32'h0);
        @(posedge clk); #1 irq_in = '1; soft_start = 1'b1; #0.5;
        chk("R10", "all requests forwarded", {31'h0, irq_pass == 33'h1_FFFF_FFFF}, 32'h1);
        @(posedge clk); #1 irq_in = '0; soft_start = 1'b0;
        quiet("R10");

        // R2/R4/R5: byte units, upper address bits set, count 2
        setup(0, 32'hAB00_0011, 32'h00FF_FFF3, 16'd2, 7'b000_01_00, 6'd5);
        pulse(5, 1'b0); expect_unit(0);
        pulse(5, 1'b0); expect_unit(0);
        pulse(5, 1'b1); quiet("R5");

        // R3/R4: word units at odd addresses, top vector code 33
        setup(1, 32'h0012_3457, 32'h0020_0001, 16'd3, 7'b001_10_01, 6'd33);
        for (int k = 0; k < 3; k++) begin pulse(33, 1'b0); expect_unit(1); end
        pulse(33, 1'b1); quiet("R6");

        // R4/R5: long units, destination steps below zero, count 0 means 65536
        setup(2, 32'h0000_0100, 32'h0000_0002, 16'd0, 7'b010_00_10, 6'd1);
        for (int k = 0; k < 3; k++) begin pulse(1, 1'b0); expect_unit(2); end
        chk("R5", "zero count still armed", {26'h0, m_vsel[2]}, 32'd1);

        // R6: software start code 34
        setup(3, 32'h0000_0040, 32'h0000_0080, 16'd1, 7'b001_01_10, 6'd34);
        @(posedge clk); #1 soft_start = 1'b1;
        @(posedge clk); #1 soft_start = 1'b0;
        expect_unit(3);

        // R7: simultaneous triggers, lower channel first
        setup(1, 32'h0000_0300, 32'h0000_0400, 16'd5, 7'b001_01_00, 6'd10);
        @(posedge clk); #1 irq_in[0] = 1'b1; irq_in[9] = 1'b1;
        @(posedge clk); #1 irq_in = '0;
        expect_unit(1); expect_unit(2); quiet("R7");

        // R8: two triggers while pending give one unit
        setup(0, 32'h0000_0500, 32'h0000_0600, 16'd4, 7'b001_01_00, 6'd7);
        setup(3, 32'h0000_0700, 32'h0000_0800, 16'd4, 7'b001_01_00, 6'd8);
        @(posedge clk); #1 irq_in[7] = 1'b1;
        @(posedge clk); #1 irq_in[7] = 1'b0; irq_in[6] = 1'b1;
        @(posedge clk);
        @(posedge clk); #1 irq_in = '0;
        expect_unit(3); expect_unit(0); quiet("R8");

        // R9: counting mode, then a normal unit reveals the stepped source
        setup(0, 32'h0000_0900, 32'h0000_0A00, 16'd3, 7'b100_01_01, 6'd12);
        pulse(12, 1'b0); expect_count(0);
        pulse(12, 1'b0); expect_count(0);
        cfg(0, 3'd3, 32'h0000_0015);
        pulse(12, 1'b0); expect_unit(0);
        pulse(12, 1'b1); quiet("R9");

        // R11: rewriting a field moves the next read
        cfg(2, 3'd0, 32'h0000_0C0C);
        pulse(1, 1'b0); expect_unit(2);

        // random channel setups (R3, R4, R5)
        for (int r = 0; r < 40; r++) begin
            int c, n, v;
            c = int'($urandom_range(3, 0));
            n = int'($urandom_range(3, 1));
            v = int'($urandom_range(33, 1));
            for (int o = 0; o < 4; o++) if (o != c) cfg(o, 3'd4, 32'h0);
            setup(c, $urandom, $urandom, 16'(n), {1'b0, 6'($urandom)}, 6'(v));
            for (int k = 0; k < n; k++) begin pulse(v, 1'b0); expect_unit(c); end
            chk("R5", "random channel released", {26'h0, m_vsel[c]}, 32'h0);
        end
        quiet("R1");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule